// File: doc/BRIEF.md
# Fused multiply-add significand core

This block is the arithmetic heart of a double-precision fused multiply-add. It takes three finite, normalized operands, already unpacked into sign, unbiased exponent and significand with the hidden bit set, and computes x*y + z without rounding the product first. The product significand is kept at its full double width. The addend is placed in the same wide frame, and the operand with the smaller exponent is shifted right. Bits shifted out are folded into a sticky bit. The two are then added, or the smaller magnitude is taken from the larger. The result is normalized so that its leading one sits at a fixed position.

The result goes to a separate rounder. It is a sign, a widened signed exponent, and a significand of 53 bits plus guard, round and sticky bits, with the leading one at the top. An exact cancellation is reported as a zero result, and its sign follows the rounding-direction input. When the addend is flagged as zero, the add step is skipped and the product alone is normalized and handed on. Two negate controls flip the sign of the product and of the addend, which covers the four multiply-add/subtract variants. Special values (NaN, infinity, zero multiplicands) and the final rounding stay with the surrounding logic.

The core is a fixed-latency pipeline that accepts one operation per cycle. `in_valid` marks an operation, and `out_valid` rises a fixed number of cycles later together with its result.

Top module: `fma_core`

## Requirements
- R1: With `z_zero` set, the result equals the product x*y. The sign is x_sign^y_sign^neg_prod, the exponent is x_exp+y_exp, and the significand is the product significand normalized and passed through with no addend.
- R2: When the product of the two significands is 2.0 or more, the result exponent is one higher than x_exp+y_exp and the significand is shifted right by one, keeping the lost bit as sticky.
- R3: Of the product and the addend, the one with the smaller exponent is shifted right by the exponent difference. Every bit shifted out is ORed into the lowest bit. A difference larger than the frame leaves only that sticky bit.
- R4: When the effective signs are equal, the magnitudes add and the result takes that sign. A carry past the leading position raises the exponent by one with a sticky right shift.
- R5: When the effective signs differ, the smaller magnitude is subtracted from the larger and the result takes the sign of the larger.
- R6: An exact zero difference gives `res_zero`=1, `res_sig`=0, `res_exp`=0, and `res_sign` equal to `round_down`.
- R7: After a subtraction, leading zeros are removed so the top significand bit is one, and the exponent drops by the number of positions shifted.
- R8: For every nonzero result, `res_sig` has its MSB set. Bit 0 is the OR of every bit of the exact result that falls below bit 1 (sticky), so `res_sig`*2^(res_exp-55) equals the exact value truncated with sticky.
- R9: `neg_prod` inverts the product sign and `neg_add` inverts the addend sign before the add/subtract decision.
- R10: `out_valid` follows `in_valid` after exactly 2+REG_MID clock cycles (3 by default). Back-to-back operations come out in order, one per cycle.
- R11: While `out_valid` is low, `res_sig`, `res_exp`, `res_sign` and `res_zero` keep their last values.
- R12: During reset, `out_valid` is 0 and all result outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| x_sign | input | 1 | Sign of multiplicand x |
| x_exp | input | 13 | Unbiased signed exponent of x |
| x_sig | input | 53 | Significand of x, hidden bit at MSB |
| y_sign | input | 1 | Sign of multiplicand y |
| y_exp | input | 13 | Unbiased signed exponent of y |
| y_sig | input | 53 | Significand of y, hidden bit at MSB |
| z_sign | input | 1 | Sign of addend z |
| z_exp | input | 13 | Unbiased signed exponent of z |
| z_sig | input | 53 | Significand of z, hidden bit at MSB |
| z_zero | input | 1 | Addend is zero; skip the add step |
| neg_prod | input | 1 | Invert the product sign |
| neg_add | input | 1 | Invert the addend sign |
| round_down | input | 1 | Rounding toward minus infinity, selects the sign of an exact zero |
| out_valid | output | 1 | Result valid |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Signed result exponent, widened for underflow |
| res_sig | output | 56 | Normalized significand plus guard, round and sticky bits |
| res_zero | output | 1 | Exact zero result |

## Verification
On every cycle the assertions check three things: the latency and ordering of `out_valid` against `in_valid`, that each nonzero result has its leading bit set while a zero result has a clean significand and exponent, and that the outputs stay still between results. Whether the value is right cannot be seen that way. The bench sweeps a narrowed configuration of the core, with 5-bit significands and a 16-bit frame, across every pair of multiplicand significands, a spread of exponent gaps and all sign and negate combinations. It compares each result against the exact sum computed as an integer, then truncated with sticky. Cancellation to zero, product carry, deep alignment into the sticky bit and long renormalization are only shown by these scenarios.

// File: rtl/fma_pkg.sv
package fma_pkg;

   // Which combining step the middle stage applies
   typedef enum logic [1:0] {
      PATH_ADD  = 2'd0,
      PATH_SUB  = 2'd1,
      PATH_PROD = 2'd2
   } fma_path_e;

endpackage

// File: rtl/fma_srl_sticky.sv
// Logical right shift; every bit pushed out is ORed into bit 0.
// A shift of W or more leaves only the sticky bit.
module fma_srl_sticky #(
   parameter int W    = 127,
   parameter int SH_W = 8
) (
   input  logic [W-1:0]    in_vec,
   input  logic [SH_W-1:0] shamt,
   output logic [W-1:0]    out_vec
);
   logic [W-1:0] keep_mask;
   logic [W-1:0] lost;

   always_comb begin
      keep_mask = ~({W{1'b1}} << shamt);
      lost      = in_vec & keep_mask;
      out_vec   = (in_vec >> shamt) | {{(W-1){1'b0}}, |lost};
   end
endmodule

// File: rtl/fma_lzc.sv
// Leading-zero count of a W-bit vector (W when the vector is zero).
module fma_lzc #(
   parameter int W  = 127,
   parameter int CW = 8
) (
   input  logic [W-1:0]  in_vec,
   output logic [CW-1:0] count
);
   always_comb begin
      count = CW'(W);
      for (int i = 0; i < W; i++) begin
         if (in_vec[i]) count = CW'(W - 1 - i);
      end
   end
endmodule

// File: rtl/fma_sig_mul.sv
// Significand product. Each operand is moved to the top of a HALF_W word;
// the product then has its leading one at bit 2*HALF_W-1 or 2*HALF_W-2.
// The output frame is one bit narrower, with the leading one at its MSB.
module fma_sig_mul #(
   parameter int MANT_W = 53,
   parameter int HALF_W = 64,
   parameter bit SPLIT  = 1'b1
) (
   input  logic [MANT_W-1:0]     a_sig,
   input  logic [MANT_W-1:0]     b_sig,
   output logic [2*HALF_W-2:0]   prod,
   output logic                  bump
);
   localparam int F   = 2 * HALF_W;
   localparam int H   = HALF_W / 2;
   localparam int PAD = HALF_W - MANT_W;

   logic [HALF_W-1:0] a_w, b_w;
   logic [F-1:0]      raw;

   assign a_w = HALF_W'(a_sig) << PAD;
   assign b_w = HALF_W'(b_sig) << PAD;

   generate
      if (SPLIT) begin : g_split
         // four half-word partial products summed with carries
         logic [HALF_W-1:0] pp_ll, pp_hh, pp_lh, pp_hl;
         always_comb begin
            pp_ll = HALF_W'(a_w[H-1:0])      * HALF_W'(b_w[H-1:0]);
            pp_hh = HALF_W'(a_w[HALF_W-1:H]) * HALF_W'(b_w[HALF_W-1:H]);
            pp_lh = HALF_W'(a_w[H-1:0])      * HALF_W'(b_w[HALF_W-1:H]);
            pp_hl = HALF_W'(a_w[HALF_W-1:H]) * HALF_W'(b_w[H-1:0]);
            raw   = {pp_hh, pp_ll} + (F'(pp_lh) << H) + (F'(pp_hl) << H);
         end
      end else begin : g_direct
         always_comb raw = F'(a_w) * F'(b_w);
      end
   endgenerate

   always_comb begin
      bump = raw[F-1];
      prod = bump ? {raw[F-1:2], raw[1] | raw[0]} : raw[F-2:0];
   end
endmodule

// File: rtl/fma_core.sv
module fma_core
   import fma_pkg::*;
#(
   parameter int FRAC_W    = 52,
   parameter int HALF_W    = 64,
   parameter int EXP_W     = 13,
   parameter bit MUL_SPLIT = 1'b1,
   parameter bit REG_MID   = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic                     x_sign,
   input  logic signed [EXP_W-1:0]  x_exp,
   input  logic [FRAC_W:0]          x_sig,
   input  logic                     y_sign,
   input  logic signed [EXP_W-1:0]  y_exp,
   input  logic [FRAC_W:0]          y_sig,
   input  logic                     z_sign,
   input  logic signed [EXP_W-1:0]  z_exp,
   input  logic [FRAC_W:0]          z_sig,
   input  logic                     z_zero,
   input  logic                     neg_prod,
   input  logic                     neg_add,
   input  logic                     round_down,
   output logic                     out_valid,
   output logic                     res_sign,
   output logic signed [EXP_W+1:0]  res_exp,
   output logic [FRAC_W+3:0]        res_sig,
   output logic                     res_zero
);
   localparam int MANT_W = FRAC_W + 1;
   localparam int F      = 2 * HALF_W;      // frame including carry bit
   localparam int W      = F - 1;           // datapath, leading one at W-1
   localparam int OUT_W  = MANT_W + 3;
   localparam int FIN_SH = W - OUT_W;       // hand-off shift to the rounder
   localparam int ZPAD   = W - MANT_W;      // addend placement
   localparam int SH_W   = $clog2(F) + 1;
   localparam int IE_W   = EXP_W + 2;
   localparam int LAT    = 2 + int'(REG_MID);

   generate
      if ((HALF_W % 2) != 0 || HALF_W <= MANT_W) begin : g_bad_half
         $error("fma_core: HALF_W must be even and wider than the significand");
      end
      if (FIN_SH < 1) begin : g_bad_out
         $error("fma_core: frame too narrow for the rounder hand-off");
      end
      if (IE_W <= SH_W) begin : g_bad_exp
         $error("fma_core: EXP_W too small for the frame");
      end
   endgenerate

   // ---------------- stage 0: product, placement, alignment ----------------
   logic                    rs, zs, bump, d_pos;
   logic [W-1:0]            prod_n, z_frame, p_al, a_al;
   logic signed [IE_W-1:0]  re, zew, ediff, exp_al;
   logic [IE_W-1:0]         emag;
   logic [SH_W-1:0]         amt, p_amt, a_amt;
   fma_path_e               path_n;

   fma_sig_mul #(.MANT_W(MANT_W), .HALF_W(HALF_W), .SPLIT(MUL_SPLIT)) u_mul (
      .a_sig (x_sig),
      .b_sig (y_sig),
      .prod  (prod_n),
      .bump  (bump)
   );

   always_comb begin
      rs      = x_sign ^ y_sign ^ neg_prod;
      zs      = z_sign ^ neg_add;
      re      = IE_W'(x_exp) + IE_W'(y_exp) + IE_W'(bump);
      zew     = IE_W'(z_exp);
      z_frame = W'(z_sig) << ZPAD;
      ediff   = zew - re;
      d_pos   = !ediff[IE_W-1] && (ediff != '0);
      emag    = ediff[IE_W-1] ? -ediff : ediff;
      amt     = (emag >= IE_W'(F)) ? SH_W'(F) : SH_W'(emag);
      p_amt   = (z_zero || !d_pos) ? '0 : amt;
      a_amt   = (z_zero ||  d_pos) ? '0 : amt;
      exp_al  = (!z_zero && d_pos) ? zew : re;
      if (z_zero)        path_n = PATH_PROD;
      else if (rs == zs) path_n = PATH_ADD;
      else               path_n = PATH_SUB;
   end

   fma_srl_sticky #(.W(W), .SH_W(SH_W)) u_align_p (
      .in_vec (prod_n), .shamt (p_amt), .out_vec (p_al)
   );
   fma_srl_sticky #(.W(W), .SH_W(SH_W)) u_align_a (
      .in_vec (z_frame), .shamt (a_amt), .out_vec (a_al)
   );

   logic                    s1_valid, s1_rs, s1_zs, s1_rdn;
   fma_path_e               s1_path;
   logic signed [IE_W-1:0]  s1_exp;
   logic [W-1:0]            s1_p, s1_a;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_rs    <= 1'b0;
         s1_zs    <= 1'b0;
         s1_rdn   <= 1'b0;
         s1_path  <= PATH_PROD;
         s1_exp   <= '0;
         s1_p     <= '0;
         s1_a     <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_rs   <= rs;
            s1_zs   <= zs;
            s1_rdn  <= round_down;
            s1_path <= path_n;
            s1_exp  <= exp_al;
            s1_p    <= p_al;
            s1_a    <= z_zero ? '0 : a_al;
         end
      end
   end

   // ---------------- stage 1: add / subtract / normalize ----------------
   logic [F-1:0]            sum;
   logic [W-1:0]            dif, mid_mag;
   logic                    a_ge, mid_sign, mid_zero;
   logic [SH_W-1:0]         lz;
   logic signed [IE_W-1:0]  mid_exp;

   always_comb begin
      sum  = {1'b0, s1_a} + {1'b0, s1_p};
      a_ge = (s1_a >= s1_p);
      dif  = a_ge ? (s1_a - s1_p) : (s1_p - s1_a);
   end

   fma_lzc #(.W(W), .CW(SH_W)) u_lzc (.in_vec (dif), .count (lz));

   always_comb begin
      mid_mag  = s1_p;
      mid_exp  = s1_exp;
      mid_sign = s1_rs;
      mid_zero = 1'b0;
      unique case (s1_path)
         PATH_ADD: begin
            mid_sign = s1_zs;
            if (sum[F-1]) begin
               mid_mag = {sum[F-1:2], sum[1] | sum[0]};
               mid_exp = s1_exp + IE_W'(1);
            end else begin
               mid_mag = sum[W-1:0];
            end
         end
         PATH_SUB: begin
            if (dif == '0) begin
               mid_zero = 1'b1;
               mid_sign = s1_rdn;
               mid_mag  = '0;
               mid_exp  = '0;
            end else begin
               mid_sign = a_ge ? s1_zs : s1_rs;
               mid_mag  = dif << lz;
               mid_exp  = s1_exp - IE_W'(lz);
            end
         end
         default: begin
            mid_mag  = s1_p;
         end
      endcase
   end

   logic                    s2_valid, s2_sign, s2_zero;
   logic signed [IE_W-1:0]  s2_exp;
   logic [W-1:0]            s2_mag;

   generate
      if (REG_MID) begin : g_mid_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s2_valid <= 1'b0;
               s2_sign  <= 1'b0;
               s2_zero  <= 1'b0;
               s2_exp   <= '0;
               s2_mag   <= '0;
            end else begin
               s2_valid <= s1_valid;
               if (s1_valid) begin
                  s2_sign <= mid_sign;
                  s2_zero <= mid_zero;
                  s2_exp  <= mid_exp;
                  s2_mag  <= mid_mag;
               end
            end
         end
      end else begin : g_mid_wire
         always_comb begin
            s2_valid = s1_valid;
            s2_sign  = mid_sign;
            s2_zero  = mid_zero;
            s2_exp   = mid_exp;
            s2_mag   = mid_mag;
         end
      end
   endgenerate

   // ---------------- output: hand-off shift with sticky ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_sign  <= 1'b0;
         res_exp   <= '0;
         res_sig   <= '0;
         res_zero  <= 1'b0;
      end else begin
         out_valid <= s2_valid;
         if (s2_valid) begin
            res_sign <= s2_sign;
            res_exp  <= s2_exp;
            res_zero <= s2_zero;
            res_sig  <= {s2_mag[W-1:FIN_SH+1],
                         s2_mag[FIN_SH] | (|s2_mag[FIN_SH-1:0])};
         end
      end
   end
endmodule

// File: rtl/fma_core_chk.sv
module fma_core_chk #(
   parameter int OUT_W = 56,
   parameter int IE_W  = 15,
   parameter int LAT   = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic                    out_valid,
   input logic signed [IE_W-1:0]  res_exp,
   input logic [OUT_W-1:0]        res_sig,
   input logic                    res_zero
);
   logic [LAT-1:0] vpipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vpipe <= '0;
      else        vpipe <= {vpipe[LAT-2:0], in_valid};
   end

   AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == vpipe[LAT-1]);                                      // R10

   AST_LEADING_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !res_zero) |-> res_sig[OUT_W-1]);                  // R8

   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_zero) |-> (res_sig == '0 && res_exp == '0));   // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(res_sig) && $stable(res_exp) && $stable(res_zero))); // R11
endmodule

bind fma_core fma_core_chk #(.OUT_W(OUT_W), .IE_W(IE_W), .LAT(LAT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .res_exp   (res_exp),
   .res_sig   (res_sig),
   .res_zero  (res_zero)
);

// File: tb/fma_core_test.sv
module fma_core_test;
   localparam int FRAC_W = 4;
   localparam int HALF_W = 8;
   localparam int EXP_W  = 6;
   localparam int OUT_W  = FRAC_W + 4;
   localparam int OL     = OUT_W - 1;
   localparam int LAT    = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic x_sign = 1'b0, y_sign = 1'b0, z_sign = 1'b0;
   logic signed [EXP_W-1:0] x_exp = '0, y_exp = '0, z_exp = '0;
   logic [FRAC_W:0] x_sig = '0, y_sig = '0, z_sig = '0;
   logic z_zero = 1'b0, neg_prod = 1'b0, neg_add = 1'b0, round_down = 1'b0;
   logic out_valid, res_sign, res_zero;
   logic signed [EXP_W+1:0] res_exp;
   logic [OUT_W-1:0] res_sig;

   always #5 clk = ~clk;

   fma_core #(.FRAC_W(FRAC_W), .HALF_W(HALF_W), .EXP_W(EXP_W),
              .MUL_SPLIT(1'b1), .REG_MID(1'b1)) uut (.*);

   typedef struct {
      bit    sign;
      int    exp;
      int    sig;
      bit    zero;
      string tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int errors = 0;

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL R10 watchdog: actual=hung expected=finished");
      summary();
   end

   // exact x*y+z, truncated with sticky to OUT_W bits
   task automatic model(input int xm, xe, ym, ye, zm, ze,
                        input bit xs, ys, zs, zz, np, na, rd, output exp_t e);
      longint pm, s, m;
      int pe, zb, b, p, el;
      bit sp, sz, stk;
      pm = longint'(xm * ym);
      pe = xe + ye - 2 * FRAC_W;
      zb = ze - FRAC_W;
      sp = xs ^ ys ^ np;
      sz = zs ^ na;
      if (zz) begin
         b = pe;
         s = sp ? -pm : pm;
      end else begin
         b = (pe < zb) ? pe : zb;
         s = (sp ? -(pm <<< (pe - b)) : (pm <<< (pe - b)))
           + (sz ? -(longint'(zm) <<< (zb - b)) : (longint'(zm) <<< (zb - b)));
      end
      stk = 1'b0;
      if (s == 0) begin
         e.sign = rd; e.exp = 0; e.sig = 0; e.zero = 1'b1;
      end else begin
         e.sign = (s < 0);
         m = (s < 0) ? -s : s;
         p = 0;
         for (int i = 0; i < 63; i++) if (m[i]) p = i;
         e.exp  = p + b;
         e.zero = 1'b0;
         if (p >= OL) begin
            stk   = ((m & ((64'd1 << (p - OL)) - 1)) != 0);
            e.sig = int'(m >> (p - OL)) | int'(stk);
         end else begin
            e.sig = int'(m << (OL - p));
         end
      end
      // requirement tags for this vector
      el = xe + ye + ((pm >= (64'd1 << (2 * FRAC_W + 1))) ? 1 : 0);
      if (zz)              e.tag = (el != xe + ye) ? "R2" : "R1";
      else if (e.zero)     e.tag = "R6";
      else if (sp == sz)   e.tag = "R4";
      else                 e.tag = "R5";
      if (!zz && ((ze - xe - ye) >= 2 || (xe + ye - ze) >= 2)) e.tag = {e.tag, "/R3"};
      if (!zz && sp != sz && !e.zero && e.exp < ((ze > el) ? ze : el)) e.tag = {e.tag, "/R7"};
      if (stk) e.tag = {e.tag, "/R8"};
      if (np || na) e.tag = {e.tag, "/R9"};
   endtask

   task automatic tick();
      exp_t e;
      @(negedge clk);
      if (out_valid) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R10 unexpected result: actual=out_valid expected=idle");
         end else begin
            e = q.pop_front();
            checks++;
            if (res_zero !== e.zero || res_sign !== e.sign ||
                int'(res_exp) != e.exp || int'(res_sig) != e.sig) begin
               errors++;
               $display("FAIL %s: actual sign=%0d exp=%0d sig=%h zero=%0d expected sign=%0d exp=%0d sig=%h zero=%0d",
                        e.tag, res_sign, int'(res_exp), res_sig, res_zero,
                        e.sign, e.exp, e.sig[OUT_W-1:0], e.zero);
            end
         end
      end
   endtask

   task automatic issue(input int xm, xe, ym, ye, zm, ze,
                        input bit xs, ys, zs, zz, np, na, rd);
      exp_t e;
      model(xm, xe, ym, ye, zm, ze, xs, ys, zs, zz, np, na, rd, e);
      tick();
      q.push_back(e);
      in_valid = 1'b1;
      x_sig = (FRAC_W+1)'(xm); x_exp = EXP_W'(xe); x_sign = xs;
      y_sig = (FRAC_W+1)'(ym); y_exp = EXP_W'(ye); y_sign = ys;
      z_sig = (FRAC_W+1)'(zm); z_exp = EXP_W'(ze); z_sign = zs;
      z_zero = zz; neg_prod = np; neg_add = na; round_down = rd;
   endtask

   task automatic drain();
      tick();
      in_valid = 1'b0;
      for (int i = 0; i < 10 && q.size() != 0; i++) tick();
      if (q.size() != 0) begin
         checks++; errors++;
         $display("FAIL R10 missing results: actual=%0d pending expected=0", q.size());
         q.delete();
      end
   endtask

   initial begin
      int offs[11] = '{-12, -6, -3, -2, -1, 0, 1, 2, 3, 6, 12};
      int lat_seen;
      logic [OUT_W-1:0] h_sig;
      logic signed [EXP_W+1:0] h_exp;
      logic h_sign, h_zero;

      // R12: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || res_sig !== '0 || res_exp !== '0 || res_zero !== 1'b0) begin
         errors++;
         $display("FAIL R12 reset: actual valid=%0d sig=%h exp=%0d expected 0", out_valid, res_sig, res_exp);
      end
      rst_n = 1'b1;

      // R1/R2: product only, every significand pair
      for (int xi = 0; xi < 16; xi++)
         for (int yi = 0; yi < 16; yi++)
            issue(16 + xi, (xi % 7) - 3, 16 + yi, (yi % 5) - 2, 16, 0,
                  xi[0], yi[1], 1'b0, 1'b1, yi[2], 1'b0, 1'b0);

      // R3/R4/R5/R7/R8/R9: full sweep over pairs and exponent gaps
      for (int xi = 0; xi < 16; xi++)
         for (int yi = 0; yi < 16; yi++)
            for (int k = 0; k < 11; k++) begin
               int xe = (xi % 7) - 3;
               int ye = (yi % 5) - 2;
               issue(16 + xi, xe, 16 + yi, ye,
                     16 + ((xi * 3 + yi * 5 + k) % 16), xe + ye + offs[k],
                     xi[0], yi[1], k[0] ^ yi[0] ^ xi[2], 1'b0,
                     ((xi + yi) % 4) == 1, ((xi + k) % 3) == 2, yi[2] ^ k[1]);
            end

      // R6: exact cancellation, both rounding directions
      for (int yi = 0; yi < 16; yi++)
         for (int r = 0; r < 2; r++)
            issue(16, 1, 16 + yi, -1, 16 + yi, 0,
                  yi[0], 1'b0, ~yi[0], 1'b0, 1'b0, 1'b0, r[0]);
      drain();

      // R10: latency of an isolated operation
      repeat (4) @(negedge clk);
      in_valid = 1'b1; x_sig = 5'd20; y_sig = 5'd18; z_zero = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      lat_seen = 0;
      for (int c = 1; c <= 8; c++) begin
         if (out_valid && lat_seen == 0) lat_seen = c;
         if (c < 8) @(negedge clk);
      end
      checks++;
      if (lat_seen != LAT) begin
         errors++;
         $display("FAIL R10 latency: actual=%0d expected=%0d", lat_seen, LAT);
      end

      // R11: outputs hold while idle and inputs move
      @(negedge clk);
      h_sig = res_sig; h_exp = res_exp; h_sign = res_sign; h_zero = res_zero;
      for (int c = 0; c < 5; c++) begin
         x_sig = 5'd17 + 5'(c); z_zero = c[0]; neg_prod = c[1]; x_exp = EXP_W'(c);
         @(negedge clk);
         checks++;
         if (out_valid || res_sig !== h_sig || res_exp !== h_exp ||
             res_sign !== h_sign || res_zero !== h_zero) begin
            errors++;
            $display("FAIL R11 hold: actual sig=%h exp=%0d expected sig=%h exp=%0d",
                     res_sig, res_exp, h_sig, h_exp);
         end
      end

      summary();
   end
endmodule